// File: doc/BRIEF.md
# Dual-Rail Early-Output AND Stage

This block is one stage of a delay-insensitive pipeline. It computes a bitwise AND of two dual-rail operands. Every lane encodes one bit on two wires. The stage issues each lane's result as soon as the operands that have arrived settle it. A zero on either operand gives a zero output straight away, without waiting for the other operand. A one is issued only once both operands have arrived as one.

Upstream and downstream use a four-phase return-to-zero handshake. The stage raises its input acknowledge only when every lane of both operands holds data and the downstream side has acknowledged the result. It drops that acknowledge only when every operand lane has returned to the empty state and the downstream acknowledge is low. A lane's output is held until both of its own operands have returned to empty. Because of this, an operand that arrives late after an early zero cannot be mistaken for the next item. The state-holding join is a Muller C-element. It is modelled as a clocked register that sets when all of its inputs are high, clears when all of its inputs are low, and otherwise holds.

A sticky error flag records any illegal code seen on an operand or on the output.

The port-level flow control is this handshake rather than a valid/ready pair. Back-pressure works as follows. While the downstream acknowledge stays high, no empty output lane can accept a new result. The input acknowledge cannot complete its cycle until the downstream acknowledge has fallen again.

Top module: `dr_eo_and_stage`

## Requirements
- R1: Lane i uses rails [2i+1] (true rail) and [2i] (false rail). The code 00 is empty, 01 is logic zero and 10 is logic one. Once both operands of a lane have arrived, that lane's output is the AND of the two operands.
- R2: An output lane never shows the code 11.
- R3: A lane's output is empty and the downstream acknowledge is low. If either operand of that lane then shows logic zero, the lane's output becomes logic zero at the next clock, whatever the state of the other operand.
- R4: A lane's output becomes logic one only when both of its operands showed logic one at the preceding clock. With one operand at one and the other empty, the lane's output stays empty.
- R5: A valid lane output holds its value while either operand of that lane is non-empty or the downstream acknowledge is low. It becomes empty at the clock after both operands are empty and the downstream acknowledge is high.
- R6: The input acknowledge rises only at the clock after every operand lane is valid and the downstream acknowledge is high. A missing late operand keeps it low even when early zeros have already been issued and acknowledged.
- R7: Once high, the input acknowledge falls only at the clock after every operand lane is empty and the downstream acknowledge is low.
- R8: While the active-low reset is asserted, all output rails, the input acknowledge and the error flag are zero.
- R9: An operand lane showing 11 sets the error flag at the next clock. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state-holding elements |
| rst_n | input | 1 | Active-low reset |
| opa_rails | input | 2*LANES | Dual-rail operand A, two rails per lane |
| opb_rails | input | 2*LANES | Dual-rail operand B, two rails per lane |
| in_ack | output | 1 | Acknowledge to the upstream side |
| res_rails | output | 2*LANES | Dual-rail result, two rails per lane |
| res_ack | input | 1 | Acknowledge from the downstream side |
| proto_err | output | 1 | Sticky illegal-code flag |

## Verification
The bench builds the stage with its default of four lanes. A single item can therefore carry all four operand combinations at once, and it always exercises the join across lanes inside the C-element. In each item one operand is chosen to arrive late. This makes it possible to observe, at the ports, the early zeros and the empty lanes that are waiting for a one. A directed case acknowledges an all-zero early result before the late operand arrives. It shows that the input acknowledge waits for that operand.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam logic [1:0] DR_EMPTY = 2'b00;
  localparam logic [1:0] DR_ZERO  = 2'b01;
  localparam logic [1:0] DR_ONE   = 2'b10;
  localparam logic [1:0] DR_BAD   = 2'b11;
endpackage

// File: rtl/dr_muller.sv
module dr_muller #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic         q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= 1'b0;
    else if (&din)     q <= 1'b1;
    else if (~|din)    q <= 1'b0;
  end

  // R6 / R7: the element changes only when its inputs agree
  a_r6_set_only_on_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !(&din)) |=> !q);
  a_r7_clear_only_on_none: assert property (@(posedge clk) disable iff (!rst_n)
    (q && (|din)) |=> q);
endmodule

// File: rtl/dr_complete.sv
module dr_complete
  import dr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0] opa,
  input  logic [2*LANES-1:0] opb,
  output logic [LANES-1:0]   a_valid,
  output logic [LANES-1:0]   b_valid,
  output logic               bad_code
);
  logic [LANES-1:0] a_bad, b_bad;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign a_valid[i] = opa[2*i+1] | opa[2*i];
    assign b_valid[i] = opb[2*i+1] | opb[2*i];
    assign a_bad[i]   = opa[2*i+1 -: 2] == DR_BAD;
    assign b_bad[i]   = opb[2*i+1 -: 2] == DR_BAD;
  end

  assign bad_code = |{a_bad, b_bad};
endmodule

// File: rtl/dr_eo_lane.sv
module dr_eo_lane
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       y_ack,
  output logic [1:0] y
);
  logic       zero_seen, both_one, both_empty;
  logic [1:0] y_nxt;

  assign zero_seen  = (a == DR_ZERO) || (b == DR_ZERO);
  assign both_one   = (a == DR_ONE) && (b == DR_ONE);
  assign both_empty = (a == DR_EMPTY) && (b == DR_EMPTY);

  always_comb begin
    y_nxt = y;
    if (y == DR_EMPTY) begin
      if (!y_ack) begin
        if (zero_seen)     y_nxt = DR_ZERO;
        else if (both_one) y_nxt = DR_ONE;
      end
    end else if (both_empty && y_ack) begin
      y_nxt = DR_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) y <= DR_EMPTY;
    else        y <= y_nxt;
  end

  a_r2_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    y != DR_BAD);
  a_r3_early_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (y == DR_EMPTY && !y_ack && (a == DR_ZERO || b == DR_ZERO)) |=> y == DR_ZERO);
  a_r4_one_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (y == DR_EMPTY && !(a == DR_ONE && b == DR_ONE)) |=> y != DR_ONE);
  a_r5_hold_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (y != DR_EMPTY && !(a == DR_EMPTY && b == DR_EMPTY && y_ack)) |=> $stable(y));
endmodule

// File: rtl/dr_eo_and_stage.sv
module dr_eo_and_stage
  import dr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LANES-1:0] opa_rails,
  input  logic [2*LANES-1:0] opb_rails,
  output logic               in_ack,
  output logic [2*LANES-1:0] res_rails,
  input  logic               res_ack,
  output logic               proto_err
);
  localparam int JOIN_W = 2*LANES + 1;

  logic [LANES-1:0] a_valid, b_valid;
  logic             in_bad, out_bad;
  logic [LANES-1:0] lane_bad;

  dr_complete #(.LANES(LANES)) u_complete (
    .opa      (opa_rails),
    .opb      (opb_rails),
    .a_valid  (a_valid),
    .b_valid  (b_valid),
    .bad_code (in_bad)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dr_eo_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (opa_rails[2*i+1 -: 2]),
      .b     (opb_rails[2*i+1 -: 2]),
      .y_ack (res_ack),
      .y     (res_rails[2*i+1 -: 2])
    );
    assign lane_bad[i] = res_rails[2*i+1 -: 2] == DR_BAD;
  end

  assign out_bad = |lane_bad;

  dr_muller #(.N(JOIN_W)) u_join (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({a_valid, b_valid, res_ack}),
    .q     (in_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                proto_err <= 1'b0;
    else if (in_bad || out_bad) proto_err <= 1'b1;
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r6_ack_waits_for_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ack && !((&a_valid) && (&b_valid) && res_ack)) |=> !in_ack);
  a_r7_ack_waits_for_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && ((|a_valid) || (|b_valid) || res_ack)) |=> in_ack);
endmodule

// File: tb/dr_eo_and_stage_tb.sv
module dr_eo_and_stage_tb;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2*L-1:0] opa = '0, opb = '0;
  logic           res_ack = 1'b0;
  logic           in_ack, proto_err;
  logic [2*L-1:0] res;
  int             checks = 0, failures = 0, cycles = 0;
  bit             saw_bad = 1'b0;

  always #2 clk = ~clk;

  dr_eo_and_stage #(.LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .opa_rails(opa), .opb_rails(opb),
    .in_ack(in_ack), .res_rails(res), .res_ack(res_ack), .proto_err(proto_err)
  );

  function automatic logic [1:0] enc(input bit v);
    return v ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [2*L-1:0] enc_vec(input logic [L-1:0] v);
    logic [2*L-1:0] r;
    for (int i = 0; i < L; i++) r[2*i+1 -: 2] = enc(v[i]);
    return r;
  endfunction

  function automatic logic [2*L-1:0] early_exp(input logic [L-1:0] v);
    logic [2*L-1:0] r;
    for (int i = 0; i < L; i++) r[2*i+1 -: 2] = v[i] ? 2'b00 : 2'b01;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    check(!saw_bad, "R2", 32'(saw_bad), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n)
      for (int i = 0; i < L; i++) if (res[2*i+1 -: 2] == 2'b11) saw_bad = 1'b1;
    if (cycles > 100000) begin
      check(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  task automatic run_item(input bit late_b, input logic [L-1:0] av, input logic [L-1:0] bv,
                          input bit early_ack);
    logic [L-1:0]   ev = late_b ? av : bv;
    logic [2*L-1:0] full = enc_vec(av & bv);
    @(negedge clk);
    if (late_b) opa = enc_vec(av); else opb = enc_vec(bv);
    repeat (2) @(negedge clk);
    // R3 zeros issued early, R4 ones wait for the late operand
    check(res == early_exp(ev), "R3/R4 early", 32'(res), 32'(early_exp(ev)));
    check(in_ack == 1'b0, "R6 late missing", 32'(in_ack), 0);
    if (early_ack) begin
      res_ack = 1'b1;
      repeat (3) @(negedge clk);
      check(in_ack == 1'b0, "R6 acked early zeros", 32'(in_ack), 0);
    end
    if (late_b) opb = enc_vec(bv); else opa = enc_vec(av);
    @(negedge clk);
    check(res == full, "R1 and result", 32'(res), 32'(full));
    if (early_ack) begin
      check(in_ack == 1'b1, "R6 rise", 32'(in_ack), 1);
    end else begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      check(in_ack == 1'b0, "R6 before res_ack", 32'(in_ack), 0);
      res_ack = 1'b1;
      @(negedge clk);
      check(in_ack == 1'b1, "R6 rise", 32'(in_ack), 1);
    end
    if ($urandom_range(0, 1) == 1) opa = '0; else opb = '0;
    repeat (2) @(negedge clk);
    check(res == full, "R5 hold", 32'(res), 32'(full));
    opa = '0; opb = '0;
    @(negedge clk);
    check(res == '0, "R5 empty", 32'(res), 0);
    check(in_ack == 1'b1, "R7 ack held", 32'(in_ack), 1);
    res_ack = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R7 fall", 32'(in_ack), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(res == '0 && in_ack == 1'b0 && proto_err == 1'b0, "R8 reset",
          {res, in_ack, proto_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res == '0 && in_ack == 1'b0, "R8 after release", {res, in_ack}, 0);
    // directed: all four combinations, each operand late
    run_item(1'b1, 4'b0011, 4'b0101, 1'b0);
    run_item(1'b0, 4'b0011, 4'b0101, 1'b0);
    // directed: early all-zero result acknowledged before the late operand
    run_item(1'b1, 4'b0000, 4'b1111, 1'b1);
    run_item(1'b0, 4'b1010, 4'b0000, 1'b1);
    run_item(1'b1, 4'b1111, 4'b1111, 1'b0);
    for (int n = 0; n < 40; n++)
      run_item(1'($urandom_range(0, 1)), L'($urandom()), L'($urandom()), 1'b0);
    check(proto_err == 1'b0, "R9 clean", 32'(proto_err), 0);
    @(negedge clk);
    opa[1:0] = 2'b11;
    @(negedge clk);
    check(proto_err == 1'b1, "R9 set", 32'(proto_err), 1);
    opa = '0;
    repeat (3) @(negedge clk);
    check(proto_err == 1'b1, "R9 sticky", 32'(proto_err), 1);
    finish_run();
  end
endmodule